// File: doc/BRIEF.md
# I2C Bit-Timing Generator with Edge Delays

This block produces the serial clock for an I2C master from a fast core clock and decides, within each clock period, when outgoing data may change and when incoming data is read. The period length comes from a divider input. Two delays, counted in core clocks, place the data launch after the falling edge of SCL and the data sample after the rising edge. The launch point gives the line time to settle while SCL is low. The sample point lets a freshly driven bit arrive before it is read.

A controller above this block presents the next transmit bit on `tx_bit_i` and takes the received bit from `rx_bit_o` when `sample_o` pulses. The two delays arrive as one packed word and are stored in a holding register on a load strobe. The divider and the stored delays are copied into the working settings only at the start of an SCL period. Start and stop conditions, byte framing, acknowledge handling and clock stretching belong to the controller.

Top module: `i2c_bit_timer`

## Requirements
- R1: With enable high, SCL repeats with a period of D core clocks, where D is the effective divider. SCL is low for floor(D/2) clocks, starting with the falling edge, and high for the remaining D - floor(D/2) clocks.
- R2: The effective divider is the divider input forced into the range 2 to 0xFFFE: values below 2 act as 2 and 0xFFFF acts as 0xFFFE.
- R3: `launch_o` pulses F clocks after each SCL falling edge, where F is the effective falling-edge delay. In that same cycle `sda_o` takes the value `tx_bit_i` had at the clock edge that raised `launch_o`. `sda_o` does not change in any other cycle and resets to 1.
- R4: `sample_o` pulses S clocks after each SCL rising edge, where S is the effective rising-edge delay. In that same cycle `rx_bit_o` takes the value `sda_in_i` had at that clock edge. When floor(D/2) + S equals D, the sample falls on the cycle of the next falling edge.
- R5: A load strobe stores the delay word: bits 31:16 give the falling-edge delay and bits 15:0 give the rising-edge delay.
- R6: After reset, before any load, both stored delays are 30 core clocks.
- R7: A stored delay above floor(D/2) acts as floor(D/2).
- R8: A stored delay of 0 acts as 1, so neither strobe ever falls on the cycle of its own SCL edge.
- R9: The divider input and the stored delays are copied into the working settings only at the start of a period. A change made during a period first affects the following period.
- R10: While enable is low, SCL is high from the next cycle and no strobe is issued. When enable rises, SCL falls on the next cycle and a new period begins.
- R11: `launch_o` and `sample_o` are single-cycle pulses. `rx_bit_o` changes only in a cycle where `sample_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the SCL generator |
| div_i | input | DIV_W | SCL period in core clocks |
| del_word_i | input | 2*DEL_W | Packed delays: falling-edge delay high, rising-edge delay low |
| del_load_i | input | 1 | Stores `del_word_i` into the delay holding register |
| tx_bit_i | input | 1 | Next bit to drive on SDA |
| sda_in_i | input | 1 | Incoming SDA level |
| scl_o | output | 1 | Serial clock |
| sda_o | output | 1 | Outgoing SDA data |
| launch_o | output | 1 | One-cycle strobe when `sda_o` takes a new bit |
| sample_o | output | 1 | One-cycle strobe when `rx_bit_o` captures SDA |
| rx_bit_o | output | 1 | Captured receive bit |

## Verification
The bench builds the block with its default 16-bit divider and 16-bit delay fields. With these widths the upper divider limit of 0xFFFE fits in a single run, and the reset delay of 30 is visible against a divider of 100. Small dividers such as 2, 3, 9 and 20 bring the narrow cases within reach: a launch on the rising edge, a sample that wraps onto the next falling edge, and delays clamped or raised to 1. A sequence with different settings in each period shows that changes made during a period take effect only at the next period boundary.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;

    // Registered per-cycle timing outputs of the phase generator
    typedef struct packed {
        logic scl;
        logic launch;
        logic sample;
    } bt_tick_t;

    localparam bt_tick_t TICK_IDLE = '{scl: 1'b1, launch: 1'b0, sample: 1'b0};

endpackage

// File: rtl/i2c_bt_delay_hold.sv
module i2c_bt_delay_hold #(
    parameter int DEL_W   = 16,
    parameter int RST_DEL = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [2*DEL_W-1:0] word_i,
    output logic [DEL_W-1:0]   fall_o,
    output logic [DEL_W-1:0]   rise_o
);

    typedef struct packed {
        logic [DEL_W-1:0] fall;
        logic [DEL_W-1:0] rise;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_i) begin
            hold_d.fall = word_i[2*DEL_W-1:DEL_W];
            hold_d.rise = word_i[DEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q.fall <= DEL_W'(RST_DEL);
            hold_q.rise <= DEL_W'(RST_DEL);
        end else begin
            hold_q <= hold_d;
        end
    end

    assign fall_o = hold_q.fall;
    assign rise_o = hold_q.rise;

    AST_WORD_SPLIT: assert property (@(posedge clk) disable iff (!rst_n) load_i |=> (fall_o == $past(word_i[2*DEL_W-1:DEL_W])) && (rise_o == $past(word_i[DEL_W-1:0]))); // R5

endmodule

// File: rtl/i2c_bt_phase_gen.sv
module i2c_bt_phase_gen
    import i2c_bt_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int DEL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic [DEL_W-1:0] fall_del_i,
    input  logic [DEL_W-1:0] rise_del_i,
    output bt_tick_t         tick_o,
    output bt_tick_t         tick_nx_o
);

    localparam int XW = ((DIV_W > DEL_W) ? DIV_W : DEL_W) + 1;
    localparam logic [DIV_W-1:0] DIV_LO  = DIV_W'(2);
    localparam logic [DIV_W-1:0] DIV_HI  = {{(DIV_W-1){1'b1}}, 1'b0};
    localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

    typedef struct packed {
        logic             run;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] half;
        logic [DIV_W-1:0] fdl;
        logic [DIV_W-1:0] rdl;
        logic [DIV_W:0]   smp_at;
        bt_tick_t         tk;
    } st_t;

    st_t st_d, st_q;

    logic             start;
    logic [DIV_W-1:0] div_c;
    logic [DIV_W-1:0] half_c;
    logic [DIV_W-1:0] fdl_c;
    logic [DIV_W-1:0] rdl_c;

    function automatic logic [DIV_W-1:0] fit_div(input logic [DIV_W-1:0] v);
        if (v < DIV_LO) return DIV_LO;
        if (v > DIV_HI) return DIV_HI;
        return v;
    endfunction

    function automatic logic [DIV_W-1:0] fit_del(input logic [DEL_W-1:0] v,
                                                 input logic [DIV_W-1:0] lim);
        logic [XW-1:0] vx;
        logic [XW-1:0] lx;
        vx = XW'(v);
        lx = XW'(lim);
        if (v == '0) return CNT_ONE;
        if (vx > lx) return lim;
        return DIV_W'(vx);
    endfunction

    always_comb begin
        div_c  = fit_div(div_i);
        half_c = div_c >> 1;
        fdl_c  = fit_del(fall_del_i, half_c);
        rdl_c  = fit_del(rise_del_i, half_c);
        start  = !st_q.run || (st_q.cnt == st_q.div - CNT_ONE);

        st_d = st_q;
        if (!en_i) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.tk  = TICK_IDLE;
        end else begin
            st_d.run = 1'b1;
            if (start) begin
                st_d.cnt    = '0;
                st_d.div    = div_c;
                st_d.half   = half_c;
                st_d.fdl    = fdl_c;
                st_d.rdl    = rdl_c;
                st_d.smp_at = {1'b0, half_c} + {1'b0, rdl_c};
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
            st_d.tk.scl    = (st_d.cnt >= st_d.half);
            st_d.tk.launch = !start && (st_d.cnt == st_q.fdl);
            // a sample landing exactly on the period end belongs to the next cycle 0
            st_d.tk.sample = start ? (st_q.run && (st_q.smp_at == {1'b0, st_q.div}))
                                   : ({1'b0, st_d.cnt} == st_q.smp_at);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.run    <= 1'b0;
            st_q.cnt    <= '0;
            st_q.div    <= DIV_LO;
            st_q.half   <= CNT_ONE;
            st_q.fdl    <= CNT_ONE;
            st_q.rdl    <= CNT_ONE;
            st_q.smp_at <= {1'b0, DIV_LO};
            st_q.tk     <= TICK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o    = st_q.tk;
    assign tick_nx_o = st_d.tk;

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) st_q.run |-> (st_q.cnt < st_q.div)); // R1
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n) st_q.run |-> (st_q.div >= DIV_LO) && (st_q.div <= DIV_HI)); // R2
    AST_DEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) st_q.run |-> (st_q.fdl <= st_q.half) && (st_q.rdl <= st_q.half)); // R7
    AST_DEL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) st_q.run |-> (st_q.fdl != '0) && (st_q.rdl != '0)); // R8
    AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n) (st_q.run && (st_q.cnt != '0)) |-> $stable(st_q.div) && $stable(st_q.fdl) && $stable(st_q.rdl)); // R9
    AST_IDLE_STATE: assert property (@(posedge clk) disable iff (!rst_n) !en_i |=> (tick_o == TICK_IDLE) && (st_q.cnt == '0)); // R10

endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter int DIV_W   = 16,
    parameter int DEL_W   = 16,
    parameter int RST_DEL = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [2*DEL_W-1:0] del_word_i,
    input  logic               del_load_i,
    input  logic               tx_bit_i,
    input  logic               sda_in_i,
    output logic               scl_o,
    output logic               sda_o,
    output logic               launch_o,
    output logic               sample_o,
    output logic               rx_bit_o
);

    logic [DEL_W-1:0] fall_del;
    logic [DEL_W-1:0] rise_del;
    bt_tick_t         tk;
    bt_tick_t         tk_nx;

    typedef struct packed {
        logic sda;
        logic rx;
    } io_t;

    io_t io_d, io_q;

    i2c_bt_delay_hold #(
        .DEL_W   (DEL_W),
        .RST_DEL (RST_DEL)
    ) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (del_load_i),
        .word_i (del_word_i),
        .fall_o (fall_del),
        .rise_o (rise_del)
    );

    i2c_bt_phase_gen #(
        .DIV_W (DIV_W),
        .DEL_W (DEL_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (enable_i),
        .div_i      (div_i),
        .fall_del_i (fall_del),
        .rise_del_i (rise_del),
        .tick_o     (tk),
        .tick_nx_o  (tk_nx)
    );

    always_comb begin
        io_d = io_q;
        if (tk_nx.launch) io_d.sda = tx_bit_i;
        if (tk_nx.sample) io_d.rx  = sda_in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            io_q.sda <= 1'b1;
            io_q.rx  <= 1'b0;
        end else begin
            io_q <= io_d;
        end
    end

    assign scl_o    = tk.scl;
    assign launch_o = tk.launch;
    assign sample_o = tk.sample;
    assign sda_o    = io_q.sda;
    assign rx_bit_o = io_q.rx;

    AST_LAUNCH_OFF_FALL: assert property (@(posedge clk) disable iff (!rst_n) $fell(scl_o) |-> !launch_o); // R8
    AST_SAMPLE_OFF_RISE: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_o) |-> !sample_o); // R8
    AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) launch_o |=> !launch_o); // R11
    AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sample_o |=> !sample_o); // R11
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sample_o |-> $stable(rx_bit_o)); // R11
    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !launch_o |-> $stable(sda_o)); // R3
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !enable_i |=> scl_o && !launch_o && !sample_o); // R10

endmodule

// File: tb/i2c_bit_timer_bench.sv
module i2c_bit_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] div_i = 16'd100;
    logic [31:0] del_word = 32'd0;
    logic        del_load = 1'b0;
    logic        tx_bit = 1'b0;
    logic        sda_in = 1'b0;
    logic        scl_o, sda_o, launch_o, sample_o, rx_bit_o;

    always #5 clk = ~clk;

    i2c_bit_timer u_i2c_bit_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .div_i      (div_i),
        .del_word_i (del_word),
        .del_load_i (del_load),
        .tx_bit_i   (tx_bit),
        .sda_in_i   (sda_in),
        .scl_o      (scl_o),
        .sda_o      (sda_o),
        .launch_o   (launch_o),
        .sample_o   (sample_o),
        .rx_bit_o   (rx_bit_o)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // event kinds: 0 SCL fall, 1 SCL rise, 2 launch, 3 sample
    typedef struct {
        int   kind;
        int   at;
        logic val;
    } ev_t;

    ev_t         evq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    string       cur_tag = "";
    int          pend_f = 30;
    int          pend_r = 30;
    int          sdiv[8];
    logic [31:0] sword[8];
    bit          sload[8];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, cur_tag, what, act, exp);
        end
    endtask

    function automatic void push(input int k, input int at, input logic v);
        ev_t e;
        e.kind = k;
        e.at   = at;
        e.val  = v;
        evq.push_back(e);
    endfunction

    function automatic int cdiv(input int d);
        if (d < 2) return 2;
        if (d > 65534) return 65534;
        return d;
    endfunction

    function automatic int cdel(input int v, input int h);
        if (v == 0) return 1;
        if (v > h) return h;
        return v;
    endfunction

    function automatic logic txpat(input int p);
        return logic'(((p * 5 + 1) >> 1) & 1);
    endfunction

    function automatic logic rxpat(input int p);
        return logic'(((p * 3 + 2) >> 1) & 1) ^ logic'(p & 1);
    endfunction

    function automatic string req_of(input int k);
        if (k < 2) return "R1";
        if (k == 2) return "R3";
        return "R4";
    endfunction

    // scoreboard monitor
    task automatic take(input int k, input logic v);
        ev_t e;
        if (evq.size() == 0) begin
            chk(1'b0, req_of(k), "unexpected event kind", k, -1);
        end else begin
            e = evq.pop_front();
            chk(e.kind == k, req_of(k), "event kind", k, e.kind);
            chk(e.at == cyc, req_of(k), "event cycle", cyc, e.at);
            if (k >= 2) chk(e.val == v, req_of(k), "data value", int'(v), int'(e.val));
        end
    endtask

    logic scl_prev = 1'b1;
    logic launch_prev = 1'b0;
    logic sample_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_o != scl_prev) take(scl_o ? 1 : 0, 1'b0);
            if (launch_o) begin
                chk(!launch_prev, "R11", "launch longer than one cycle", 1, 0);
                take(2, sda_o);
            end
            if (sample_o) begin
                chk(!sample_prev, "R11", "sample longer than one cycle", 1, 0);
                take(3, rx_bit_o);
            end
            scl_prev    = scl_o;
            launch_prev = launch_o;
            sample_prev = sample_o;
        end
    end

    task automatic wait_cyc(input int t);
        while (cyc != t) @(negedge clk);
    endtask

    task automatic idle_check(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            chk(scl_o && !launch_o && !sample_o, "R10", "idle outputs (scl,launch,sample)",
                int'({scl_o, launch_o, sample_o}), 4);
        end
    endtask

    task automatic clear_seq();
        for (int i = 0; i < 8; i++) begin
            sdiv[i]  = 2;
            sword[i] = 32'd0;
            sload[i] = 1'b0;
        end
    endtask

    task automatic run_seq(input int n, input string tag);
        int   F, d, h, fd, rd;
        bit   wrap_prev;
        logic wrap_val;
        wrap_prev = 1'b0;
        wrap_val  = 1'b0;
        cur_tag   = tag;
        if (sload[0]) begin
            del_word = sword[0];
            del_load = 1'b1;
            @(negedge clk);
            del_load = 1'b0;
            pend_f = int'(sword[0][31:16]);
            pend_r = int'(sword[0][15:0]);
        end
        div_i  = 16'(sdiv[0]);
        enable = 1'b1;
        F = cyc + 1;
        for (int p = 0; p < n; p++) begin
            d  = cdiv(sdiv[p]);
            h  = d / 2;
            fd = cdel(pend_f, h);
            rd = cdel(pend_r, h);
            push(0, F, 1'b0);
            if (wrap_prev) push(3, F, wrap_val);
            if (fd < h) begin
                push(2, F + fd, txpat(p));
                push(1, F + h, 1'b0);
            end else begin
                push(1, F + h, 1'b0);
                push(2, F + fd, txpat(p));
            end
            if (h + rd < d) push(3, F + h + rd, rxpat(p));
            wrap_prev = (h + rd == d) && (p < n - 1);
            wrap_val  = rxpat(p);
            wait_cyc(F);
            tx_bit = txpat(p);
            if (p + 1 < n) begin
                div_i = 16'(sdiv[p + 1]);
                if (sload[p + 1]) begin
                    del_word = sword[p + 1];
                    del_load = 1'b1;
                end
            end
            wait_cyc(F + 1);
            if (del_load) begin
                del_load = 1'b0;
                pend_f = int'(sword[p + 1][31:16]);
                pend_r = int'(sword[p + 1][15:0]);
            end
            wait_cyc(F + h);
            sda_in = rxpat(p);
            if (p == n - 1) begin
                wait_cyc(F + d - 1);
                enable = 1'b0;
            end
            F = F + d;
        end
        repeat (3) @(negedge clk);
        chk(evq.size() == 0, "R1", "missing expected events", evq.size(), 0);
        evq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_o && !launch_o && !sample_o && sda_o && !rx_bit_o, "R10", "reset outputs",
            int'({scl_o, launch_o, sample_o, sda_o, rx_bit_o}), 5'b10010);
        rst_n = 1'b1;
        idle_check(3);

        // R6: no load after reset, delays are 30
        clear_seq();
        sdiv[0] = 100; sdiv[1] = 100;
        run_seq(2, "R6 reset delays");
        idle_check(4);

        // R5: packed word, falling delay in 31:16, rising in 15:0
        clear_seq();
        sdiv[0] = 40; sdiv[1] = 40; sdiv[2] = 40;
        sload[0] = 1'b1; sword[0] = 32'h0003_0005;
        run_seq(3, "R5 word split");
        idle_check(2);

        // R7: odd divider, rising delay above half is clamped, launch on rise
        clear_seq();
        sdiv[0] = 41; sdiv[1] = 41;
        sload[0] = 1'b1; sword[0] = 32'h0014_0015;
        run_seq(2, "R7 clamp odd");
        idle_check(2);

        // R8: zero delays act as one
        clear_seq();
        sdiv[0] = 20; sdiv[1] = 20; sdiv[2] = 20;
        sload[0] = 1'b1; sword[0] = 32'h0000_0000;
        run_seq(3, "R8 zero delay");
        idle_check(2);

        // R4 and R7: sample wraps onto the next falling edge
        clear_seq();
        sdiv[0] = 20; sdiv[1] = 20; sdiv[2] = 20;
        sload[0] = 1'b1; sword[0] = 32'h0032_000A;
        run_seq(3, "R4 wrap sample");
        idle_check(2);

        // R2: dividers below 2, then 3
        clear_seq();
        sdiv[0] = 1; sdiv[1] = 0; sdiv[2] = 3;
        sload[0] = 1'b1; sword[0] = 32'h0001_0001;
        run_seq(3, "R2 low divider");
        idle_check(2);

        // R9: settings changed mid-period take effect next period
        clear_seq();
        sdiv[0] = 12; sdiv[1] = 30; sdiv[2] = 9; sdiv[3] = 16;
        sload[0] = 1'b1; sword[0] = 32'h0002_0003;
        sload[1] = 1'b1; sword[1] = 32'h0007_0004;
        sload[3] = 1'b1; sword[3] = 32'h0028_0001;
        run_seq(4, "R9 period boundary");
        idle_check(2);

        // R2: top of range
        clear_seq();
        sdiv[0] = 65535;
        sload[0] = 1'b1; sword[0] = 32'h0064_00C8;
        run_seq(1, "R2 high divider");
        idle_check(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule